// File: doc/BRIEF.md
# Fracturable Lookup Table Cell

A configurable K-input lookup table for a programmable logic cell. A truth-table vector of 2^K bits holds the function. The K user inputs pick one entry of that vector through a binary multiplexer tree. Before an input reaches the tree, it can pass through a per-pin gate. The gate can pin that input to a constant under control of a mode-select configuration bit. The parameter `GATE_MAP` chooses, for each pin, whether it is wired straight through, gated by an AND (it can be forced low), or gated by an OR (it can be forced high).

When the top input is forced, one physical table splits into two (K-1)-input tables. Their results appear on extra outputs taken from the two nodes just below the tree root. The tree is built dual-rail. Each configuration vector has a complementary partner, and each select line is carried in true and complemented form. The complement rail of the tree therefore reads the complementary truth table at the same index.

The cell is purely combinational. An unsupported map code, or a mismatch between the number of gated pins and `MODE_W`, stops elaboration with an error.

Top module: `lutf_cell`

## Requirements
- R1: `lut_out[0]` equals `tt_bits[g]`. `g` is the gated input vector, with pin 0 as its least significant bit.
- R2: A pin whose 2-bit map code (bits `[2p+1:2p]` of `GATE_MAP`) is 0 reaches the tree unchanged. With `tt_bits` = 16'hAAAA, `lut_out[0]` follows `lut_in[0]`.
- R3: For a pin with map code 1 (AND gate), a mode bit of 0 drives that pin to 0 in `g`, and a mode bit of 1 passes the user input. In the default map, pin 3 is AND-gated.
- R4: For a pin with map code 2 (OR gate), a mode bit of 1 drives that pin to 1 in `g`, and a mode bit of 0 passes the user input. In the default map, pin 2 is OR-gated.
- R5: Mode bits are assigned to gated pins in ascending pin order. Pass-through pins are skipped. In the default map, `msel[0]` controls pin 2 and `msel[1]` controls pin 3.
- R6: With `SPLIT` = 1, there are two extra outputs:
  - `lut_out[1]` = `tt_bits[{0, g[K-2:0]}]`, the lower half of the table.
  - `lut_out[2]` = `tt_bits[{1, g[K-2:0]}]`, the upper half of the table.
- R7: When `msel_n` is the bitwise complement of `msel`, every `lut_out_n[i]` reads `tt_bits_n` at the index used by `lut_out[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lut_in | input | K | User inputs, pin 0 least significant |
| tt_bits | input | 2**K | Truth-table configuration |
| tt_bits_n | input | 2**K | Complementary truth-table configuration |
| msel | input | MODE_W | Mode-select bits, one per gated pin |
| msel_n | input | MODE_W | Complementary mode-select bits |
| lut_out | output | OUT_W (3 if SPLIT else 1) | Full-table result, then lower-half and upper-half results |
| lut_out_n | output | OUT_W | Complement-rail results read from `tt_bits_n` |

## Verification
The bound checker recomputes the gated index from the ports, whatever the inputs. It compares the full lookup, both half-table lookups and the complement rail against that index. It also checks that forcing the top pin collapses the full result onto the matching half result. The ordering of mode bits across gated pins cannot be seen by the checker, because it derives the gating from the same map. Only the bench shows that ordering, using tables that isolate single pins under each mode combination. The same holds for pass-through behaviour on chosen patterns and for the rail with an independent complementary table.

// File: rtl/lutf_pkg.sv
package lutf_pkg;

    // Upper bound on the number of table inputs; sizes the map vector.
    localparam int MAX_PINS = 16;
    localparam int MAP_W    = 2 * MAX_PINS;

    // Per-pin gating kind, two bits per pin in the map vector.
    typedef enum logic [1:0] {
        GATE_NONE = 2'd0,
        GATE_AND  = 2'd1,
        GATE_OR   = 2'd2
    } gate_kind_e;

    // One select or data value carried in true and complemented form.
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    function automatic gate_kind_e pin_kind(logic [MAP_W-1:0] map, int pin);
        return gate_kind_e'(map[2*pin +: 2]);
    endfunction

    // Number of gated pins strictly below 'pin': the mode bit index of 'pin'.
    function automatic int gated_below(logic [MAP_W-1:0] map, int pin);
        int cnt = 0;
        for (int p = 0; p < pin; p++)
            if (map[2*p +: 2] != 2'd0) cnt++;
        return cnt;
    endfunction

    // Count of map entries carrying the unused code 3 within the first k pins.
    function automatic int bad_codes(logic [MAP_W-1:0] map, int k);
        int cnt = 0;
        for (int p = 0; p < k; p++)
            if (map[2*p +: 2] == 2'd3) cnt++;
        return cnt;
    endfunction

endpackage

// File: rtl/lutf_gate.sv
module lutf_gate
    import lutf_pkg::*;
#(
    parameter gate_kind_e KIND = GATE_AND
) (
    input  logic  din,
    input  logic  msel,
    input  logic  msel_n,
    output rail_t q
);

    generate
        if (KIND == GATE_AND) begin : g_and
            // mode bit low pins the select to 0
            assign q.t = din & msel;
            assign q.f = ~din | msel_n;
        end else begin : g_or
            // mode bit high pins the select to 1
            assign q.t = din | msel;
            assign q.f = ~din & msel_n;
        end
    endgenerate

endmodule

// File: rtl/lutf_node.sv
module lutf_node
    import lutf_pkg::*;
(
    input  rail_t s,
    input  rail_t d0,
    input  rail_t d1,
    output rail_t y
);

    // Dual-rail 2:1 selection: each rail picks its own data through the select pair.
    assign y.t = (s.t & d1.t) | (s.f & d0.t);
    assign y.f = (s.t & d1.f) | (s.f & d0.f);

endmodule

// File: rtl/lutf_tree.sv
module lutf_tree
    import lutf_pkg::*;
#(
    parameter int K = 4
) (
    input  rail_t [K-1:0]      sel,
    input  logic  [2**K-1:0]   tt,
    input  logic  [2**K-1:0]   tt_n,
    output rail_t              root,
    output rail_t              lo_half,
    output rail_t              hi_half
);

    localparam int ENTRIES = 1 << K;
    localparam int NODES   = 2 * ENTRIES - 1;

    // Heap-ordered nodes: index 0 is the root, leaves start at ENTRIES-1.
    rail_t node [NODES];

    generate
        for (genvar j = 0; j < ENTRIES; j++) begin : g_leaf
            assign node[ENTRIES-1+j] = '{t: tt[j], f: tt_n[j]};
        end

        // Depth d is steered by input K-1-d, so pin 0 chooses between adjacent leaves.
        for (genvar d = 0; d < K; d++) begin : g_lvl
            for (genvar n = 0; n < (1 << d); n++) begin : g_nd
                localparam int IDX = (1 << d) - 1 + n;
                lutf_node u_node (
                    .s  (sel[K-1-d]),
                    .d0 (node[2*IDX+1]),
                    .d1 (node[2*IDX+2]),
                    .y  (node[IDX])
                );
            end
        end
    endgenerate

    assign root    = node[0];
    assign lo_half = node[1];
    assign hi_half = node[2];

endmodule

// File: rtl/lutf_cell.sv
module lutf_cell
    import lutf_pkg::*;
#(
    parameter int                K        = 4,
    parameter int                MODE_W   = 2,
    parameter bit                SPLIT    = 1'b1,
    parameter logic [MAP_W-1:0]  GATE_MAP = 32'h0000_0060,
    localparam int               ENTRIES  = 1 << K,
    localparam int               OUT_W    = SPLIT ? 3 : 1
) (
    input  logic [K-1:0]        lut_in,
    input  logic [ENTRIES-1:0]  tt_bits,
    input  logic [ENTRIES-1:0]  tt_bits_n,
    input  logic [MODE_W-1:0]   msel,
    input  logic [MODE_W-1:0]   msel_n,
    output logic [OUT_W-1:0]    lut_out,
    output logic [OUT_W-1:0]    lut_out_n
);

    localparam int USED_BITS = gated_below(GATE_MAP, K);
    localparam int BAD_CODES = bad_codes(GATE_MAP, K);

    // Configuration consistency is settled at elaboration.
    generate
        if (K < 2 || K > MAX_PINS) begin : g_bad_k
            $error("lutf_cell: K=%0d outside 2..%0d", K, MAX_PINS);
        end
        if (USED_BITS != MODE_W) begin : g_bad_width
            $error("lutf_cell: map gates %0d pins but MODE_W=%0d", USED_BITS, MODE_W);
        end
        if (BAD_CODES != 0) begin : g_bad_code
            $error("lutf_cell: map holds %0d unsupported pin codes", BAD_CODES);
        end
    endgenerate

    rail_t [K-1:0] sel;
    rail_t         root, lo_half, hi_half;

    generate
        for (genvar p = 0; p < K; p++) begin : g_pin
            localparam gate_kind_e KIND = pin_kind(GATE_MAP, p);
            localparam int         MI   = gated_below(GATE_MAP, p);
            if (KIND == GATE_NONE) begin : g_wire
                assign sel[p] = '{t: lut_in[p], f: ~lut_in[p]};
            end else begin : g_gated
                lutf_gate #(.KIND(KIND)) u_gate (
                    .din    (lut_in[p]),
                    .msel   (msel[MI]),
                    .msel_n (msel_n[MI]),
                    .q      (sel[p])
                );
            end
        end
    endgenerate

    lutf_tree #(.K(K)) u_tree (
        .sel     (sel),
        .tt      (tt_bits),
        .tt_n    (tt_bits_n),
        .root    (root),
        .lo_half (lo_half),
        .hi_half (hi_half)
    );

    assign lut_out[0]   = root.t;
    assign lut_out_n[0] = root.f;

    generate
        if (SPLIT) begin : g_split
            assign lut_out[1]   = lo_half.t;
            assign lut_out_n[1] = lo_half.f;
            assign lut_out[2]   = hi_half.t;
            assign lut_out_n[2] = hi_half.f;
        end
    endgenerate

endmodule

// File: rtl/lutf_cell_chk.sv
module lutf_cell_chk
    import lutf_pkg::*;
#(
    parameter int               K        = 4,
    parameter int               MODE_W   = 2,
    parameter bit               SPLIT    = 1'b1,
    parameter logic [MAP_W-1:0] GATE_MAP = 32'h0000_0060,
    localparam int              ENTRIES  = 1 << K,
    localparam int              OUT_W    = SPLIT ? 3 : 1
) (
    input logic [K-1:0]       lut_in,
    input logic [ENTRIES-1:0] tt_bits,
    input logic [ENTRIES-1:0] tt_bits_n,
    input logic [MODE_W-1:0]  msel,
    input logic [MODE_W-1:0]  msel_n,
    input logic [OUT_W-1:0]   lut_out,
    input logic [OUT_W-1:0]   lut_out_n
);

    // Behavioural gated index, derived from the ports and the map alone.
    logic [K-1:0] ref_g;

    generate
        for (genvar p = 0; p < K; p++) begin : g_ref
            localparam gate_kind_e KIND = pin_kind(GATE_MAP, p);
            localparam int         MI   = gated_below(GATE_MAP, p);
            if (KIND == GATE_AND) begin : g_a
                assign ref_g[p] = msel[MI] ? lut_in[p] : 1'b0;
            end else if (KIND == GATE_OR) begin : g_o
                assign ref_g[p] = msel[MI] ? 1'b1 : lut_in[p];
            end else begin : g_n
                assign ref_g[p] = lut_in[p];
            end
        end
    endgenerate

    always_comb begin
        AST_FULL_LOOKUP: assert (lut_out[0] == tt_bits[ref_g]) else $error("full lookup mismatch"); // R1
        if (msel_n == ~msel) begin
            AST_COMP_RAIL: assert (lut_out_n[0] == tt_bits_n[ref_g]) else $error("complement rail mismatch"); // R7
        end
    end

    generate
        if (SPLIT) begin : g_halves
            always_comb begin
                AST_LOW_HALF: assert (lut_out[1] == tt_bits[{1'b0, ref_g[K-2:0]}]) else $error("lower half mismatch"); // R6
                AST_HIGH_HALF: assert (lut_out[2] == tt_bits[{1'b1, ref_g[K-2:0]}]) else $error("upper half mismatch"); // R6
            end

            localparam gate_kind_e TOP_KIND = pin_kind(GATE_MAP, K-1);
            localparam int         TOP_MI   = gated_below(GATE_MAP, K-1);
            if (TOP_KIND == GATE_AND) begin : g_top_and
                always_comb begin
                    if (!msel[TOP_MI]) begin
                        AST_AND_SPLIT: assert (lut_out[0] == lut_out[1]) else $error("forced-low top pin"); // R3
                    end
                end
            end else if (TOP_KIND == GATE_OR) begin : g_top_or
                always_comb begin
                    if (msel[TOP_MI]) begin
                        AST_OR_SPLIT: assert (lut_out[0] == lut_out[2]) else $error("forced-high top pin"); // R4
                    end
                end
            end
        end
    endgenerate

endmodule

bind lutf_cell lutf_cell_chk #(
    .K        (K),
    .MODE_W   (MODE_W),
    .SPLIT    (SPLIT),
    .GATE_MAP (GATE_MAP)
) u_chk (
    .lut_in    (lut_in),
    .tt_bits   (tt_bits),
    .tt_bits_n (tt_bits_n),
    .msel      (msel),
    .msel_n    (msel_n),
    .lut_out   (lut_out),
    .lut_out_n (lut_out_n)
);

// File: tb/lutf_cell_test.sv
module lutf_cell_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [3:0]  lut_in    = '0;
    logic [15:0] tt_bits   = '0;
    logic [15:0] tt_bits_n = '0;
    logic [1:0]  msel      = '0;
    logic [1:0]  msel_n    = '0;
    logic [2:0]  lut_out;
    logic [2:0]  lut_out_n;

    lutf_cell uut (
        .lut_in    (lut_in),
        .tt_bits   (tt_bits),
        .tt_bits_n (tt_bits_n),
        .msel      (msel),
        .msel_n    (msel_n),
        .lut_out   (lut_out),
        .lut_out_n (lut_out_n)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // Default map: pin 2 OR-gated by msel[0], pin 3 AND-gated by msel[1].
    function automatic int gated(logic [3:0] x, logic [1:0] m);
        int g = int'(x);
        if (m[0])  g = g | 4;
        if (!m[1]) g = g & ~8;
        return g;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (tt=%h m=%b x=%h)", tag, act, exp, tt_bits, msel, lut_in);
        end
    endtask

    task automatic drive(logic [15:0] t, logic [15:0] tn, logic [1:0] m, logic [1:0] mn, logic [3:0] x);
        @(posedge clk);
        tt_bits = t; tt_bits_n = tn; msel = m; msel_n = mn; lut_in = x;
        @(negedge clk);
    endtask

    // Compare every output against the behavioural model.
    task automatic check_model();
        int g  = gated(lut_in, msel);
        int lo = g % 8;
        chk("R1 full lookup", lut_out[0], tt_bits[g]);
        chk("R6 lower half", lut_out[1], tt_bits[lo]);
        chk("R6 upper half", lut_out[2], tt_bits[8 + lo]);
        if (msel_n == ~msel) begin
            chk("R7 complement full", lut_out_n[0], tt_bits_n[g]);
            chk("R7 complement lower", lut_out_n[1], tt_bits_n[lo]);
            chk("R7 complement upper", lut_out_n[2], tt_bits_n[8 + lo]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        logic [15:0] t;
        logic [15:0] tn;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Zero configuration: every output reads table entry 0.
        chk("R1 reset state out0", lut_out[0], 1'b0);
        chk("R6 reset state out1", lut_out[1], 1'b0);
        chk("R6 reset state out2", lut_out[2], 1'b0);
        rst = 1'b0;

        // R2: pins 0 and 1 pass straight through.
        for (int x = 0; x < 16; x++) begin
            drive(16'hAAAA, 16'h5555, 2'b10, 2'b01, 4'(x));
            chk("R2 pin0 pass", lut_out[0], lut_in[0]);
            check_model();
        end
        for (int x = 0; x < 16; x++) begin
            drive(16'hCCCC, 16'h3333, 2'b10, 2'b01, 4'(x));
            chk("R2 pin1 pass", lut_out[0], lut_in[1]);
        end

        // R3: table selects pin 3, which is AND-gated by msel[1].
        for (int x = 0; x < 16; x++) begin
            drive(16'hFF00, 16'h00FF, 2'b00, 2'b11, 4'(x));
            chk("R3 and forced low", lut_out[0], 1'b0);
            drive(16'hFF00, 16'h00FF, 2'b10, 2'b01, 4'(x));
            chk("R3 and pass", lut_out[0], lut_in[3]);
        end

        // R4: table selects pin 2, which is OR-gated by msel[0].
        for (int x = 0; x < 16; x++) begin
            drive(16'hF0F0, 16'h0F0F, 2'b11, 2'b00, 4'(x));
            chk("R4 or forced high", lut_out[0], 1'b1);
            drive(16'hF0F0, 16'h0F0F, 2'b10, 2'b01, 4'(x));
            chk("R4 or pass", lut_out[0], lut_in[2]);
        end

        // R5: table = pin2 & pin3; each mode pair reveals which bit drives which pin.
        for (int x = 0; x < 16; x++) begin
            drive(16'hF000, 16'h0FFF, 2'b01, 2'b10, 4'(x));
            chk("R5 m=01", lut_out[0], 1'b0);
            drive(16'hF000, 16'h0FFF, 2'b11, 2'b00, 4'(x));
            chk("R5 m=11", lut_out[0], lut_in[3]);
            drive(16'hF000, 16'h0FFF, 2'b10, 2'b01, 4'(x));
            chk("R5 m=10", lut_out[0], lut_in[2] & lut_in[3]);
        end

        // Random tables over every mode and input, with both matched and
        // independent complementary tables.
        for (int r = 0; r < 8; r++) begin
            t  = 16'($urandom);
            tn = (r % 2 == 0) ? ~t : 16'($urandom);
            for (int m = 0; m < 4; m++) begin
                for (int x = 0; x < 16; x++) begin
                    drive(t, tn, 2'(m), ~2'(m), 4'(x));
                    check_model();
                end
            end
        end

        // R7 with a matched pair: the complement rail is the exact inverse.
        for (int x = 0; x < 16; x++) begin
            drive(16'h6B2D, 16'h94D2, 2'b10, 2'b01, 4'(x));
            chk("R7 inverse rail", lut_out_n[0], ~lut_out[0]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule